// File: doc/BRIEF.md
# Four-Group Interrupt Trigger Latch

This block collects raw interrupt trigger lines and holds them as pending bits that software can read and acknowledge. Each instance takes 128 inputs in four groups of 32. The top module pairs two instances, which gives 256 sources. A source's index fixes its instance, group and bit, so a source added later takes the next free index and leaves every existing position where it was.

Each bit has a crossing style that is fixed at build time:
- **Direct** for sources already in the controller clock.
- **Two-flop synchroniser** for sources in another clock.
- **Toggle-to-pulse** for sources that signal by changing level.

A run-time select register chooses, bit by bit, whether the bit is captured on a rising edge or simply follows its input level. Toggle-to-pulse bits are always captured as edges, whatever the select register holds. Per-bit enables gate capture.

An ORed summary of the pending and enabled bits is produced for each group and for each instance. A single severity wire, the OR of everything, feeds the next aggregation level. A plain register port gives write and read access. The read side has its own address, so reads never collide with writes.

Top module: `tlatch_pair`

## Requirements
- R1: After reset, every pending, enable and edge-select register reads 0, and all summary outputs and the severity output are 0.
- R2: With its edge-select bit at 1 and its enable at 1, a direct bit becomes pending on the first rising clock edge that samples its input high after the input was low. The bit stays pending after the input falls.
- R3: Writing a word to a pending register (register select 0) clears each edge-captured bit written as 1, and leaves bits written as 0 unchanged. A capture event and a clear that land on the same edge leave the bit pending.
- R4: With its edge-select bit at 0, a bit's pending value follows its enabled input one edge later. A clear write has no effect on that bit while the input is high.
- R5: A bit whose enable is 0 never becomes pending, whatever its input does.
- R6: A synchronised bit is not yet pending after two rising edges, and is pending after the third rising edge that follows its input change. The synchroniser output equals the input delayed by two edges.
- R7: A toggle-to-pulse bit becomes pending once for each change of its input, rising or falling, three edges after the change. This holds even when its edge-select bit is 0. With no further change, the bit stays clear once it has been cleared.
- R8: Source index N lands in instance N/128, group (N%128)/32, bit N%32. The register address is {instance[4], group[3:2], select[1:0]}, with select 0 = pending, 1 = enable, 2 = edge select.
- R9: A group summary is the OR of that group's pending bits that are also enabled. Bit i*4+g of `grp_sum_o` belongs to instance i, group g. The instance summary is the OR of its four group summaries, and `sev_o` is the OR of the instance summaries. Clearing an enable hides a pending bit from the summaries without clearing it.
- R10: The enable and edge-select registers read back the last value written. Register select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 256 | Raw trigger sources, index N on bit N |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write address {instance, group, select} |
| wr_data_i | input | 32 | Write data (a 1 clears a bit when select is 0) |
| rd_addr_i | input | 5 | Read address {instance, group, select} |
| rd_data_o | output | 32 | Read data, combinational from the registers |
| grp_sum_o | output | 8 | Per-group pending-and-enabled summaries |
| inst_sum_o | output | 2 | Per-instance summaries |
| sev_o | output | 1 | Severity wire to the next aggregation level |

## Verification
The results are due at different times after a stimulus:
- A direct bit's pending state is due one rising edge after its input changes.
- A synchronised or toggle bit's pending state is due three edges after its input changes. The bench also checks it after two edges, to show it is not early.
- A register write or clear shows on the read port right after the edge that performs it.

Each expectation is queued by the driver together with the cycle number at which it is due. The monitor compares it shortly after the falling edge of that cycle, once the read data has settled and before the next rising edge can move the registers.

// File: rtl/tlatch_pkg.sv
package tlatch_pkg;

    localparam int GRP_W    = 32;
    localparam int NUM_GRP  = 4;
    localparam int NUM_INST = 2;

    // register selector held in the low address bits
    typedef enum logic [1:0] {
        SEL_PEND = 2'd0,
        SEL_EN   = 2'd1,
        SEL_EDGE = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // clock-crossing style of one trigger bit
    typedef enum logic [1:0] {
        XING_DIRECT = 2'd0,
        XING_SYNC2  = 2'd1,
        XING_TOGGLE = 2'd2
    } xing_e;

    // per-bit conditioned trigger: level and capture event
    typedef struct packed {
        logic lvl;
        logic evt;
    } xout_t;

    function automatic xing_e xing_of(input logic is_sync, input logic is_tog);
        if (is_tog)  return XING_TOGGLE;
        if (is_sync) return XING_SYNC2;
        return XING_DIRECT;
    endfunction

endpackage

// File: rtl/tlatch_cross.sv
module tlatch_cross
    import tlatch_pkg::*;
#(
    parameter xing_e MODE = XING_DIRECT
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  raw_i,
    output xout_t out_o
);

    logic lvl;
    logic lvl_d;

    generate
        if (MODE == XING_DIRECT) begin : g_dir
            assign lvl = raw_i;
        end else begin : g_sync
            logic       s1;
            logic       s2;
            logic [1:0] age;

            always_ff @(posedge clk) begin
                if (rst) begin
                    s1  <= 1'b0;
                    s2  <= 1'b0;
                    age <= 2'd0;
                end else begin
                    s1 <= raw_i;
                    s2 <= s1;
                    if (age != 2'd3) age <= age + 2'd1;
                end
            end
            assign lvl = s2;

            // R6
            sync_depth_chk: assert property (@(posedge clk) disable iff (rst)
                (age == 2'd3) |-> (s2 == $past(raw_i, 2)));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) lvl_d <= 1'b0;
        else     lvl_d <= lvl;
    end

    always_comb begin
        out_o.lvl = lvl;
        if (MODE == XING_TOGGLE) out_o.evt = lvl ^ lvl_d;
        else                     out_o.evt = lvl & ~lvl_d;
    end

endmodule

// File: rtl/tlatch_group.sv
module tlatch_group
    import tlatch_pkg::*;
#(
    parameter int           W        = GRP_W,
    parameter logic [W-1:0] SYNC_SEL = '0,
    parameter logic [W-1:0] TOG_SEL  = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_i,
    input  logic         pend_wr_i,
    input  logic         en_wr_i,
    input  logic         edge_wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] en_o,
    output logic [W-1:0] edge_o,
    output logic         sum_o
);

    localparam logic [W-1:0] FORCE_EDGE = TOG_SEL;

    xout_t        xo [W];
    logic [W-1:0] lvl;
    logic [W-1:0] evt;
    logic [W-1:0] pend_q, en_q, edge_q;
    logic [W-1:0] edge_eff, w1c, pend_nxt;

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            tlatch_cross #(.MODE(xing_of(SYNC_SEL[b], TOG_SEL[b]))) u_x (
                .clk   (clk),
                .rst   (rst),
                .raw_i (raw_i[b]),
                .out_o (xo[b])
            );
            assign lvl[b] = xo[b].lvl;
            assign evt[b] = xo[b].evt;
        end
    endgenerate

    always_comb begin
        edge_eff = edge_q | FORCE_EDGE;
        w1c      = pend_wr_i ? wdata_i : '0;
        pend_nxt = (edge_eff & ((pend_q & ~w1c) | (evt & en_q)))
                 | (~edge_eff & lvl & en_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            en_q   <= '0;
            edge_q <= '0;
        end else begin
            pend_q <= pend_nxt;
            if (en_wr_i)   en_q   <= wdata_i;
            if (edge_wr_i) edge_q <= wdata_i;
        end
    end

    assign pend_o = pend_q;
    assign en_o   = en_q;
    assign edge_o = edge_q;
    assign sum_o  = |(pend_q & en_q);

    // R2
    edge_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend_q & edge_eff & ~w1c) & ~pend_q) == '0));

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (|(w1c & edge_eff & ~evt)) |=> ((pend_q & $past(w1c & edge_eff & ~evt)) == '0));

    // R5
    masked_no_set_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

endmodule

// File: rtl/tlatch_unit.sv
module tlatch_unit
    import tlatch_pkg::*;
#(
    parameter int                           G        = NUM_GRP,
    parameter int                           W        = GRP_W,
    parameter logic [G*W-1:0]               SYNC_SEL = '0,
    parameter logic [G*W-1:0]               TOG_SEL  = '0,
    localparam int                          GAW      = $clog2(G)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [G*W-1:0] trig_i,
    input  logic           wr_en_i,
    input  logic [GAW-1:0] wr_grp_i,
    input  reg_sel_e       wr_sel_i,
    input  logic [W-1:0]   wr_data_i,
    input  logic [GAW-1:0] rd_grp_i,
    input  reg_sel_e       rd_sel_i,
    output logic [W-1:0]   rd_data_o,
    output logic [G-1:0]   grp_sum_o,
    output logic           sum_o
);

    logic [W-1:0] pend_a [G];
    logic [W-1:0] en_a   [G];
    logic [W-1:0] edge_a [G];

    generate
        for (genvar g = 0; g < G; g++) begin : g_grp
            logic hit;
            assign hit = wr_en_i && (wr_grp_i == GAW'(g));

            tlatch_group #(
                .W        (W),
                .SYNC_SEL (SYNC_SEL[g*W +: W]),
                .TOG_SEL  (TOG_SEL[g*W +: W])
            ) u_grp (
                .clk       (clk),
                .rst       (rst),
                .raw_i     (trig_i[g*W +: W]),
                .pend_wr_i (hit && (wr_sel_i == SEL_PEND)),
                .en_wr_i   (hit && (wr_sel_i == SEL_EN)),
                .edge_wr_i (hit && (wr_sel_i == SEL_EDGE)),
                .wdata_i   (wr_data_i),
                .pend_o    (pend_a[g]),
                .en_o      (en_a[g]),
                .edge_o    (edge_a[g]),
                .sum_o     (grp_sum_o[g])
            );
        end
    endgenerate

    always_comb begin
        unique case (rd_sel_i)
            SEL_PEND: rd_data_o = pend_a[rd_grp_i];
            SEL_EN:   rd_data_o = en_a[rd_grp_i];
            SEL_EDGE: rd_data_o = edge_a[rd_grp_i];
            default:  rd_data_o = '0;
        endcase
    end

    assign sum_o = |grp_sum_o;

endmodule

// File: rtl/tlatch_pair.sv
module tlatch_pair
    import tlatch_pkg::*;
#(
    parameter int  NI = NUM_INST,
    parameter int  NG = NUM_GRP,
    parameter int  W  = GRP_W,
    parameter logic [NI*NG*W-1:0] SYNC_SEL =
        {NI{32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0}},
    parameter logic [NI*NG*W-1:0] TOG_SEL =
        {NI{32'h0, 32'h0000_000F, 32'h0, 32'h0}},
    localparam int GAW    = $clog2(NG),
    localparam int IAW    = $clog2(NI),
    localparam int ADDR_W = 2 + GAW + IAW,
    localparam int UNIT_W = NG * W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NI*NG*W-1:0]  trig_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [W-1:0]        wr_data_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [W-1:0]        rd_data_o,
    output logic [NI*NG-1:0]    grp_sum_o,
    output logic [NI-1:0]       inst_sum_o,
    output logic                sev_o
);

    logic [IAW-1:0] wr_inst, rd_inst;
    logic [GAW-1:0] wr_grp, rd_grp;
    reg_sel_e       wr_sel, rd_sel;
    logic [W-1:0]   rd_a [NI];

    assign wr_sel  = reg_sel_e'(wr_addr_i[1:0]);
    assign wr_grp  = wr_addr_i[2 +: GAW];
    assign wr_inst = wr_addr_i[2+GAW +: IAW];
    assign rd_sel  = reg_sel_e'(rd_addr_i[1:0]);
    assign rd_grp  = rd_addr_i[2 +: GAW];
    assign rd_inst = rd_addr_i[2+GAW +: IAW];

    generate
        for (genvar i = 0; i < NI; i++) begin : g_inst
            tlatch_unit #(
                .G        (NG),
                .W        (W),
                .SYNC_SEL (SYNC_SEL[i*UNIT_W +: UNIT_W]),
                .TOG_SEL  (TOG_SEL[i*UNIT_W +: UNIT_W])
            ) u_unit (
                .clk       (clk),
                .rst       (rst),
                .trig_i    (trig_i[i*UNIT_W +: UNIT_W]),
                .wr_en_i   (wr_en_i && (wr_inst == IAW'(i))),
                .wr_grp_i  (wr_grp),
                .wr_sel_i  (wr_sel),
                .wr_data_i (wr_data_i),
                .rd_grp_i  (rd_grp),
                .rd_sel_i  (rd_sel),
                .rd_data_o (rd_a[i]),
                .grp_sum_o (grp_sum_o[i*NG +: NG]),
                .sum_o     (inst_sum_o[i])
            );
        end
    endgenerate

    assign rd_data_o = rd_a[rd_inst];
    assign sev_o     = |inst_sum_o;

endmodule

// File: tb/tlatch_pair_bench.sv
module tlatch_pair_bench;

    typedef struct {
        int          due;
        bit          is_sum;
        logic [4:0]  addr;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [255:0] trig = '0;
    logic         wr_en = 1'b0;
    logic [4:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [4:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic [7:0]   grp_sum;
    logic [1:0]   inst_sum;
    logic         sev;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    item_t sbq[$];

    tlatch_pair u_tlatch_pair (
        .clk        (clk),
        .rst        (rst),
        .trig_i     (trig),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .grp_sum_o  (grp_sum),
        .inst_sum_o (inst_sum),
        .sev_o      (sev)
    );

    always #10ns clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [4:0] A(int i, int g, int s);
        return 5'(i * 16 + g * 4 + s);
    endfunction

    // summary vector {inst_sum[1:0], grp_sum[7:0], sev}
    always @(negedge clk) begin
        #2ns;
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            item_t it;
            logic [31:0] act;
            it = sbq.pop_front();
            if (it.is_sum) begin
                act = {21'b0, inst_sum, grp_sum, sev};
            end else begin
                rd_addr = it.addr;
                #1ns;
                act = rd_data;
            end
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: addr %0h sum %0b actual %h expected %h",
                         it.req, it.addr, it.is_sum, act, it.exp);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic exp_reg(logic [4:0] a, int d, logic [31:0] e, string r);
        item_t it;
        it.due = cyc + d; it.is_sum = 1'b0; it.addr = a; it.exp = e; it.req = r;
        sbq.push_back(it);
    endtask

    task automatic exp_sum(int d, logic [31:0] e, string r);
        item_t it;
        it.due = cyc + d; it.is_sum = 1'b1; it.addr = '0; it.exp = e; it.req = r;
        sbq.push_back(it);
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #4ms;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        // R1 reset state
        exp_reg(A(0,0,0), 0, 32'h0, "R1");
        exp_reg(A(0,0,1), 0, 32'h0, "R1");
        exp_reg(A(1,3,2), 0, 32'h0, "R1");
        exp_sum(0, 32'h0, "R1");
        drain();

        // R10 readback
        wr(A(0,0,1), 32'hFFFF_FFFF);
        wr(A(0,0,2), 32'h0000_FFFF);
        exp_reg(A(0,0,1), 0, 32'hFFFF_FFFF, "R10");
        exp_reg(A(0,0,2), 0, 32'h0000_FFFF, "R10");
        exp_reg(A(0,0,3), 0, 32'h0, "R10");
        drain();

        // R2 edge capture, sticky after fall
        trig[0] = 1'b1;
        exp_reg(A(0,0,0), 1, 32'h1, "R2");
        exp_sum(1, 32'h203, "R9");
        tick(1);
        trig[0] = 1'b0;
        exp_reg(A(0,0,0), 2, 32'h1, "R2");
        drain();

        // R3 clear semantics
        wr(A(0,0,0), 32'h0);
        exp_reg(A(0,0,0), 0, 32'h1, "R3");
        wr(A(0,0,0), 32'h1);
        exp_reg(A(0,0,0), 0, 32'h0, "R3");
        exp_sum(0, 32'h0, "R9");
        drain();
        trig[1] = 1'b1; tick(1);
        trig[1] = 1'b0; tick(1);
        trig[1] = 1'b1;
        wr(A(0,0,0), 32'h2);
        exp_reg(A(0,0,0), 0, 32'h2, "R3");
        trig[1] = 1'b0;
        wr(A(0,0,0), 32'h2);
        exp_reg(A(0,0,0), 0, 32'h0, "R3");
        drain();

        // R4 level follow, clear ignored while high
        trig[16] = 1'b1;
        exp_reg(A(0,0,0), 1, 32'h0001_0000, "R4");
        tick(1);
        wr(A(0,0,0), 32'h0001_0000);
        exp_reg(A(0,0,0), 0, 32'h0001_0000, "R4");
        trig[16] = 1'b0;
        exp_reg(A(0,0,0), 1, 32'h0, "R4");
        drain();

        // R5 disabled bit never pends
        wr(A(0,0,1), 32'hFFFF_FFDF);
        trig[5] = 1'b1;
        exp_reg(A(0,0,0), 2, 32'h0, "R5");
        exp_sum(2, 32'h0, "R5");
        tick(2);
        trig[5] = 1'b0;
        drain();
        wr(A(0,0,1), 32'hFFFF_FFFF);

        // R9 enable hides but keeps pending
        trig[2] = 1'b1; tick(1);
        trig[2] = 1'b0;
        exp_sum(0, 32'h203, "R9");
        wr(A(0,0,1), 32'hFFFF_FFFB);
        exp_reg(A(0,0,0), 0, 32'h4, "R9");
        exp_sum(0, 32'h0, "R9");
        drain();
        wr(A(0,0,0), 32'h4);
        wr(A(0,0,1), 32'hFFFF_FFFF);

        // R6 synchroniser latency (source index 35)
        wr(A(0,1,1), 32'hFFFF_FFFF);
        wr(A(0,1,2), 32'hFFFF_FFFF);
        trig[35] = 1'b1;
        exp_reg(A(0,1,0), 2, 32'h0, "R6");
        exp_reg(A(0,1,0), 3, 32'h8, "R6");
        tick(3);
        drain();
        wr(A(0,1,0), 32'h8);
        exp_reg(A(0,1,0), 0, 32'h0, "R6");
        trig[35] = 1'b0;
        drain();

        // R7 toggle-to-pulse (source index 64), edge select left at 0
        wr(A(0,2,1), 32'h1);
        trig[64] = 1'b1;
        exp_reg(A(0,2,0), 2, 32'h0, "R7");
        exp_reg(A(0,2,0), 3, 32'h1, "R7");
        tick(3);
        drain();
        wr(A(0,2,0), 32'h1);
        exp_reg(A(0,2,0), 0, 32'h0, "R7");
        trig[64] = 1'b0;
        exp_reg(A(0,2,0), 3, 32'h1, "R7");
        tick(3);
        drain();
        wr(A(0,2,0), 32'h1);
        exp_reg(A(0,2,0), 4, 32'h0, "R7");
        drain();

        // R8 index mapping into the second instance
        wr(A(1,2,1), 32'hFFFF_FFFF);
        wr(A(1,2,2), 32'hFFFF_FFFF);
        wr(A(1,3,1), 32'h8000_0000);
        wr(A(1,3,2), 32'h8000_0000);
        trig[200] = 1'b1;
        exp_reg(A(1,2,0), 1, 32'h0000_0100, "R8");
        exp_reg(A(0,2,0), 1, 32'h0, "R8");
        exp_sum(1, 32'h481, "R8");
        tick(1);
        trig[255] = 1'b1;
        exp_reg(A(1,3,0), 1, 32'h8000_0000, "R8");
        exp_sum(1, 32'h581, "R9");
        drain();

        finish_run();
    end

endmodule